// File: doc/BRIEF.md
# Run-Delimiting Buffer Controller for a k-way Merge Tree

A k-way merge tree can only merge one group of sorted runs at a time. If the leaf buffers keep streaming data after their current run, an element of the next run can reach the root ahead of a valid element of the current merge, and the result is no longer sorted. This controller sits between the leaf buffers and the tree and between the root and the output buffer. It keeps each merge separate by inserting an in-band all-ones sentinel once a leaf has supplied its full run.

Each leaf gate counts the elements the tree has taken from it. Below the current run length it is transparent. When the count reaches the run length, it offers the sentinel to the tree without pause and holds back its source, so the next run stays queued. On the root side, every non-sentinel element is written to the output buffer and counted. When `WAYS × run length` elements have been stored, the controller raises a one-cycle `tree_flush`. This pulse empties the tree FIFOs and clears every counter, and on the next cycle the leaves forward the next run.

The run length is loaded at the start of a sort and multiplied by the way count at each phase change. For example, with four ways and initial runs of 16, the first phase merges into runs of 64 and the second into runs of 256. A sort of N elements takes log base `WAYS` of N/S phases, where S is the initial run length.

Top module: `run_delimiter_ctrl`

## Requirements
- R1: After synchronous reset, the run length is `INIT_RUN`, all element counters are zero, `tree_flush` is low and every leaf is transparent.
- R2: While a leaf has supplied fewer elements than the run length, `leaf_valid`/`leaf_data` follow `src_valid`/`src_data` and `src_ready` follows `leaf_ready`. A cycle with `leaf_ready` low consumes nothing and does not advance the count.
- R3: Once a leaf has supplied run-length elements, it presents `leaf_valid`=1 with `leaf_data` equal to the all-ones sentinel (32'hFFFF_FFFF) and drives `src_ready` low, whatever `src_valid` is.
- R4: The tree accepting the sentinel changes nothing: the leaf keeps offering the sentinel and keeps its source held until the next clear.
- R5: A root element is written to the output buffer (`ob_wr`=1, `ob_data`=`root_data`) in the same cycle that `root_valid` is high, unless it equals the sentinel. A sentinel is never written and is not counted. Real elements must be below the sentinel.
- R6: When the output count reaches `WAYS` × run length, `tree_flush` is high for exactly one cycle, the cycle after the last write.
- R7: In the flush cycle, `leaf_valid`, `src_ready` and `ob_wr` are all low. On the next cycle all counters are zero and the leaves forward the next run.
- R8: `phase_load` sets the run length to `run_len_in`, and `phase_advance` multiplies it by `WAYS`. Both clear every counter.
- R9: Each leaf keeps its own count: a leaf that has finished its run does not affect another leaf that is still forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_load | input | 1 | Load run length from `run_len_in`, clear counters |
| phase_advance | input | 1 | Multiply run length by `WAYS`, clear counters |
| run_len_in | input | LEN_W | Initial run length for the sort |
| src_valid | input | WAYS | Leaf buffer has an element |
| src_data | input | WAYS*32 | Leaf buffer head elements, leaf i at bits [32i+31:32i] |
| src_ready | output | WAYS | Pop the leaf buffer head |
| leaf_valid | output | WAYS | Element offered to the tree leaf |
| leaf_data | output | WAYS*32 | Elements offered to the tree leaves |
| leaf_ready | input | WAYS | Tree leaf accepts the element |
| root_valid | input | 1 | Tree root emits an element |
| root_data | input | 32 | Tree root element |
| ob_wr | output | 1 | Write enable of the output buffer |
| ob_data | output | 32 | Element written to the output buffer |
| tree_flush | output | 1 | One-cycle clear of the tree FIFOs |

## Verification
The assertions assume that `phase_load` and `phase_advance` never fall in the same cycle as the last write of a merge. They also assume that a real element never equals the sentinel, and that the run length times `WAYS` fits the counter. The bench pulses phase controls only while the root is idle and drives only small ascending values. It uses run lengths of 2, 4 and 8 with four ways.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    localparam int DATA_W = 32;
    typedef logic [DATA_W-1:0] elem_t;
    localparam elem_t SENTINEL = '1;

    function automatic logic is_sentinel(input elem_t d);
        return &d;
    endfunction
endpackage

// File: rtl/rdc_run_length.sv
module rdc_run_length #(
    parameter int WAYS     = 4,
    parameter int LEN_W    = 16,
    parameter int INIT_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_load,
    input  logic             phase_advance,
    input  logic [LEN_W-1:0] run_len_in,
    output logic [LEN_W-1:0] ep
);
    localparam int SHIFT = $clog2(WAYS);

    always_ff @(posedge clk) begin
        if (rst)                ep <= LEN_W'(INIT_RUN);
        else if (phase_load)    ep <= run_len_in;
        else if (phase_advance) ep <= ep << SHIFT;
    end

    // R8
    ep_scale_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_advance && !phase_load) |=> (ep == LEN_W'($past(ep) * WAYS)));
    // R8
    ep_load_chk: assert property (@(posedge clk) disable iff (rst)
        phase_load |=> (ep == $past(run_len_in)));
endmodule

// File: rtl/rdc_leaf_gate.sv
module rdc_leaf_gate
    import rdc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             flush,
    input  logic [LEN_W-1:0] ep,
    input  logic             src_valid,
    input  elem_t            src_data,
    output logic             src_ready,
    output logic             leaf_valid,
    output elem_t            leaf_data,
    input  logic             leaf_ready
);
    logic [LEN_W-1:0] cnt_q;
    logic             holding;
    logic             take;

    assign holding    = (cnt_q >= ep);
    assign leaf_valid = !flush && (holding || src_valid);
    assign leaf_data  = holding ? SENTINEL : src_data;
    assign src_ready  = !flush && !holding && leaf_ready;
    assign take       = src_valid && src_ready;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (take)   cnt_q <= cnt_q + 1'b1;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= ep) || $past(clr));
    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (holding && !clr) |=> (leaf_data == SENTINEL && !src_ready));
endmodule

// File: rtl/rdc_root_counter.sv
module rdc_root_counter
    import rdc_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_ctl,
    input  logic [LEN_W-1:0] ep,
    input  logic             root_valid,
    input  elem_t            root_data,
    output logic             ob_wr,
    output elem_t            ob_data,
    output logic             flush
);
    localparam int CNT_W = LEN_W + $clog2(WAYS) + 1;

    logic [CNT_W-1:0] out_cnt_q;
    logic [CNT_W-1:0] merged_len;
    logic             last_wr;

    assign merged_len = CNT_W'(ep) * CNT_W'(WAYS);
    assign ob_wr      = root_valid && !is_sentinel(root_data) && !flush;
    assign ob_data    = root_data;
    assign last_wr    = ob_wr && (out_cnt_q + 1'b1 == merged_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_cnt_q <= '0;
            flush     <= 1'b0;
        end else begin
            flush <= last_wr && !phase_ctl;
            if (flush || phase_ctl) out_cnt_q <= '0;
            else if (ob_wr)         out_cnt_q <= out_cnt_q + 1'b1;
        end
    end

    // R5
    no_sentinel_write_chk: assert property (@(posedge clk) disable iff (rst)
        ob_wr |-> !is_sentinel(ob_data));
    // R6
    flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);
    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (out_cnt_q == '0));
endmodule

// File: rtl/run_delimiter_ctrl.sv
module run_delimiter_ctrl
    import rdc_pkg::*;
#(
    parameter int WAYS     = 4,
    parameter int LEN_W    = 16,
    parameter int INIT_RUN = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   phase_load,
    input  logic                   phase_advance,
    input  logic [LEN_W-1:0]       run_len_in,
    input  logic [WAYS-1:0]        src_valid,
    input  logic [WAYS*DATA_W-1:0] src_data,
    output logic [WAYS-1:0]        src_ready,
    output logic [WAYS-1:0]        leaf_valid,
    output logic [WAYS*DATA_W-1:0] leaf_data,
    input  logic [WAYS-1:0]        leaf_ready,
    input  logic                   root_valid,
    input  logic [DATA_W-1:0]      root_data,
    output logic                   ob_wr,
    output logic [DATA_W-1:0]      ob_data,
    output logic                   tree_flush
);
    logic [LEN_W-1:0] ep;
    logic             phase_ctl;
    logic             clr;

    assign phase_ctl = phase_load || phase_advance;
    assign clr       = tree_flush || phase_ctl;

    rdc_run_length #(.WAYS(WAYS), .LEN_W(LEN_W), .INIT_RUN(INIT_RUN)) u_len (
        .clk(clk), .rst(rst), .phase_load(phase_load),
        .phase_advance(phase_advance), .run_len_in(run_len_in), .ep(ep)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_leaf
        rdc_leaf_gate #(.LEN_W(LEN_W)) u_gate (
            .clk(clk), .rst(rst), .clr(clr), .flush(tree_flush), .ep(ep),
            .src_valid(src_valid[g]),
            .src_data(src_data[g*DATA_W +: DATA_W]),
            .src_ready(src_ready[g]),
            .leaf_valid(leaf_valid[g]),
            .leaf_data(leaf_data[g*DATA_W +: DATA_W]),
            .leaf_ready(leaf_ready[g])
        );
    end

    rdc_root_counter #(.WAYS(WAYS), .LEN_W(LEN_W)) u_root (
        .clk(clk), .rst(rst), .phase_ctl(phase_ctl), .ep(ep),
        .root_valid(root_valid), .root_data(root_data),
        .ob_wr(ob_wr), .ob_data(ob_data), .flush(tree_flush)
    );

    // R7
    flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tree_flush |-> (leaf_valid == '0 && src_ready == '0 && !ob_wr));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !tree_flush);
endmodule

// File: tb/test_run_delimiter_ctrl.sv
module test_run_delimiter_ctrl;
    localparam int WAYS = 4;
    localparam int LEN_W = 16;
    localparam int DW = 32;
    localparam logic [DW-1:0] SENT = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_load = 1'b0, phase_advance = 1'b0;
    logic [LEN_W-1:0] run_len_in = '0;
    logic [WAYS-1:0] src_valid = '0, leaf_ready = '0;
    logic [WAYS*DW-1:0] src_data = '0;
    logic [WAYS-1:0] src_ready, leaf_valid;
    logic [WAYS*DW-1:0] leaf_data;
    logic root_valid = 1'b0;
    logic [DW-1:0] root_data = '0;
    logic ob_wr, tree_flush;
    logic [DW-1:0] ob_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    run_delimiter_ctrl #(.WAYS(WAYS), .LEN_W(LEN_W), .INIT_RUN(4)) i_run_delimiter_ctrl (
        .clk(clk), .rst(rst), .phase_load(phase_load), .phase_advance(phase_advance),
        .run_len_in(run_len_in), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .leaf_valid(leaf_valid), .leaf_data(leaf_data),
        .leaf_ready(leaf_ready), .root_valid(root_valid), .root_data(root_data),
        .ob_wr(ob_wr), .ob_data(ob_data), .tree_flush(tree_flush)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        phase_load = 1'b0;
        phase_advance = 1'b0;
    endtask

    function automatic logic [DW-1:0] lane(input int w);
        return leaf_data[w*DW +: DW];
    endfunction

    // Drive one leaf through n elements, then check the hold behaviour
    task automatic leaf_run(input int w, input int n, input int base, input string req);
        src_valid[w] = 1'b1;
        leaf_ready[w] = 1'b1;
        for (int i = 0; i < n; i++) begin
            src_data[w*DW +: DW] = DW'(base + i);
            #1;
            chk(leaf_valid[w] && lane(w) == DW'(base + i), req, lane(w), base + i);
            chk(src_ready[w], req, src_ready[w], 1);
            step();
        end
        src_data[w*DW +: DW] = DW'(base + n);
        #1;
        chk(leaf_valid[w] && lane(w) == SENT, {req, " R3 sentinel"}, lane(w), SENT);
        chk(!src_ready[w], {req, " R3 hold"}, src_ready[w], 0);
        step();
        #1;
        chk(lane(w) == SENT && !src_ready[w], "R4 sentinel kept", lane(w), SENT);
        src_valid[w] = 1'b0;
        leaf_ready[w] = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        #1;
        chk(!tree_flush, "R1 flush low", tree_flush, 0);
        chk(leaf_valid == '0, "R1 leaves idle", leaf_valid, 0);
        chk(!ob_wr, "R1 no write", ob_wr, 0);
    endtask

    task automatic t_leaf_backpressure();
        // R2: stall cycle does not count
        src_valid[0] = 1'b1;
        leaf_ready[0] = 1'b0;
        src_data[0 +: DW] = 32'h55;
        #1;
        chk(leaf_valid[0] && lane(0) == 32'h55, "R2 passthrough", lane(0), 32'h55);
        chk(!src_ready[0], "R2 no pop when stalled", src_ready[0], 0);
        step();
        leaf_run(0, 4, 32'h100, "R2 R1 run of INIT_RUN");
    endtask

    task automatic t_independent();
        // R9: leaf 0 holds, leaf 1 still forwards
        src_valid[0] = 1'b1;
        src_valid[1] = 1'b1;
        leaf_ready[1] = 1'b1;
        src_data[DW +: DW] = 32'h77;
        #1;
        chk(lane(0) == SENT && !src_ready[0], "R9 leaf0 held", lane(0), SENT);
        chk(lane(1) == 32'h77 && src_ready[1], "R9 leaf1 forwards", lane(1), 32'h77);
        step();
        src_valid = '0;
        leaf_ready = '0;
    endtask

    task automatic t_root(input int total, input string req);
        int written = 0;
        src_valid = '1;
        for (int i = 0; i < total; i++) begin
            if (i == 2) begin
                root_valid = 1'b1;
                root_data = SENT;
                #1;
                chk(!ob_wr, "R5 sentinel not written", ob_wr, 0);
                step();
            end
            root_valid = 1'b1;
            root_data = DW'(i + 3);
            #1;
            chk(ob_wr && ob_data == DW'(i + 3), "R5 write", ob_data, i + 3);
            chk(!tree_flush, {req, " no early flush"}, tree_flush, 0);
            step();
            written++;
        end
        root_valid = 1'b1;
        root_data = 32'h999;
        #1;
        chk(tree_flush, {req, " R6 flush after last write"}, tree_flush, 1);
        chk(leaf_valid == '0 && src_ready == '0, "R7 leaves gated", leaf_valid, 0);
        chk(!ob_wr, "R7 no write in flush", ob_wr, 0);
        root_valid = 1'b0;
        step();
        leaf_ready[0] = 1'b1;
        src_data[0 +: DW] = 32'h31;
        #1;
        chk(!tree_flush, "R6 single cycle", tree_flush, 0);
        chk(lane(0) == 32'h31 && src_ready[0], "R7 leaf resumes", lane(0), 32'h31);
        src_valid = '0;
        leaf_ready = '0;
        chk(written == total, req, written, total);
    endtask

    task automatic t_phase();
        run_len_in = 16'd2;
        phase_load = 1'b1;
        step();
        leaf_run(2, 2, 32'h200, "R8 loaded run");
        phase_advance = 1'b1;
        step();
        leaf_run(2, 8, 32'h300, "R8 advanced run");
        t_root(32, "R8 merged length");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        t_leaf_backpressure();
        t_independent();
        t_root(16, "R6 merged length");
        t_phase();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule